// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block sits in an FPGA on the far side of a host's external bus, where address and data travel over one shared set of pins. A strobe marks the address phase: while it is high the pins hold an address, and once it falls they hold data. There is no chip-select line. The slave therefore decodes the upper address bits itself against a base set by a parameter. Accesses that fall outside that window are ignored.

Address bit 8 chooses between two independent 64-word register regions, each spanning a 256-byte window. A write transfers one word, after which the slave closes the cycle on its own and waits for the next address strobe. A read drives the addressed word onto the bus while the host holds its active-low output enable low. All bus inputs pass through a two-stage synchroniser into the FPGA clock before any decision is made.

Top module: `mux_ad_slave`

## Requirements
- R1: After reset the tristate enable `ad_oe` is 0, and it stays 0 even if `oe_n` goes low before any address strobe is seen.
- R2: While `ale` is 1 the slave keeps re-latching the bus, so the address in effect is the last value present before `ale` falls.
- R3: With no address strobe since the last finished cycle, the pins are ignored: write data presented with `ale` low does not change any register.
- R4: A write (`rnw`=0) stores the bus word on the first synchronised clock with `ale` low. Exactly one word is stored per strobe, and later bus changes before the next strobe are discarded.
- R5: `ad_oe` is 1 only during a read (`rnw`=1) that hit the window, with `oe_n` low. It stays 0 during the data phase until `oe_n` falls.
- R6: Address bit 8 selects region 0 (bit 8 = 0) or region 1 (bit 8 = 1). The two regions hold separate words at the same index.
- R7: Address bits [31:9] must equal the same bits of the base (default 0x6000_0000). On a mismatch the bus stays undriven and writes are dropped.
- R8: `ad_oe` returns to 0 by the second rising clock edge after `oe_n` rises.
- R9: Address bits [7:2] pick the word within a region. Bits [1:0] do not affect which word is accessed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | FPGA clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_in | input | 32 | Shared bus as seen at the input buffer |
| ad_out | output | 32 | Word to drive onto the shared bus |
| ad_oe | output | 1 | Tristate enable for the shared bus |
| ale | input | 1 | Address strobe, high during the address phase |
| oe_n | input | 1 | Host output enable, active low |
| rnw | input | 1 | Transfer direction: 1 read, 0 write |

## Verification
The bench targets the address that changes while the strobe is high: a slave that latches only on the strobe's rising edge writes to the first address instead of the last. It holds write data on the bus after the word is taken and again with no strobe at all. A slave that fails to close its own cycle, or that ignores the strobe, then overwrites the stored word, and read-back shows it. Accesses that differ from the base only in bit 9, or only in the high nibble, must leave the bus undriven and memory untouched. A decoder that is too narrow would answer them. The bench also times the release of the tristate enable after the output enable rises, and checks that same-index words in the two regions stay separate.

// File: rtl/mux_ad_slave.sv
module mux_ad_slave #(
  parameter int          DW       = 32,
  parameter logic [31:0] BASE     = 32'h6000_0000,
  parameter int          WIN_BITS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic          ale,
  input  logic          oe_n,
  input  logic          rnw
);
  localparam int IDX_W = WIN_BITS - 2;
  localparam int DEPTH = 2 << IDX_W;
  localparam int AQ_W  = DW - 2;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_READ} st_t;

  logic [DW-1:0]   ad_s1, ad_s2;
  logic [2:0]      ctl_s1, ctl_s2;
  logic            ale_s, oen_s, rnw_s;
  logic [AQ_W-1:0] addr_q;
  logic            oe_seen;
  st_t             st;
  logic [DW-1:0]   mem [DEPTH];
  logic            hit, we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ad_s1  <= '0;
      ad_s2  <= '0;
      ctl_s1 <= 3'b011;
      ctl_s2 <= 3'b011;
    end else begin
      ad_s1  <= ad_in;
      ad_s2  <= ad_s1;
      ctl_s1 <= {ale, oe_n, rnw};
      ctl_s2 <= ctl_s1;
    end

  assign {ale_s, oen_s, rnw_s} = ctl_s2;

  assign hit = addr_q[AQ_W-1:IDX_W+1] == BASE[DW-1:WIN_BITS+1];
  assign we  = (st == S_ADDR) && !ale_s && !rnw_s && hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      oe_seen <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (ale_s) begin
            addr_q <= ad_s2[DW-1:2];
            st     <= S_ADDR;
          end
        S_ADDR:
          if (ale_s) addr_q <= ad_s2[DW-1:2];
          else if (rnw_s) begin
            st      <= S_READ;
            oe_seen <= 1'b0;
          end else st <= S_IDLE;
        S_READ:
          if (ale_s) begin
            addr_q <= ad_s2[DW-1:2];
            st     <= S_ADDR;
          end else if (!oen_s) oe_seen <= 1'b1;
          else if (oe_seen) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk)
    if (we) mem[addr_q[IDX_W:0]] <= ad_s2;

  assign ad_out = mem[addr_q[IDX_W:0]];
  assign ad_oe  = (st == S_READ) && hit && !oen_s;

  a_r4_one_word: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);
  a_r3_idle_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !ale_s) |=> st == S_IDLE);
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !ale_s) |=> $stable(addr_q));
  a_r5_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> rnw_s);
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    oen_s |-> !ad_oe);
endmodule

// File: tb/sim_mux_ad_slave.sv
module sim_mux_ad_slave;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic        ale = 0, oe_n = 1, rnw = 1;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  mux_ad_slave u0 (.clk, .rst_n, .ad_in, .ad_out, .ad_oe, .ale, .oe_n, .rnw);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    ale = 1; ad_in = a; rnw = 0; cyc(3);
    ale = 0; ad_in = d; cyc(4);
    rnw = 1; cyc(1);
  endtask

  task automatic bus_read(input string req, input logic [31:0] a, input bit exp_hit,
                          input logic [31:0] exp);
    ale = 1; ad_in = a; rnw = 1; cyc(3);
    ale = 0; ad_in = '0; cyc(3);
    chk("R5 idle before oe_n", {31'b0, ad_oe}, 32'd0);
    oe_n = 0; cyc(3);
    chk({req, " drive enable"}, {31'b0, ad_oe}, {31'b0, exp_hit});
    if (exp_hit) chk({req, " data"}, ad_out, exp);
    oe_n = 1; cyc(2);
    chk("R8 release", {31'b0, ad_oe}, 32'd0);
    cyc(2);
  endtask

  task automatic t_reset;
    cyc(4);
    chk("R1 reset oe", {31'b0, ad_oe}, 32'd0);
    rst_n = 1; cyc(2);
    oe_n = 0; cyc(4);
    chk("R1 no strobe no drive", {31'b0, ad_oe}, 32'd0);
    oe_n = 1; cyc(3);
  endtask

  task automatic t_regions;
    bus_write(32'h6000_0014, 32'hA1A1_0001);
    bus_write(32'h6000_0114, 32'hB2B2_0002);
    bus_read("R6 region0", 32'h6000_0014, 1, 32'hA1A1_0001);
    bus_read("R6 region1", 32'h6000_0114, 1, 32'hB2B2_0002);
  endtask

  task automatic t_offset;
    bus_write(32'h6000_00FC, 32'hC3C3_0003);
    bus_read("R9 byte offset ignored", 32'h6000_00FD, 1, 32'hC3C3_0003);
  endtask

  task automatic t_last_addr;
    bus_write(32'h6000_0020, 32'hE5E5_0005);
    ale = 1; rnw = 0; ad_in = 32'h6000_0020; cyc(3);
    ad_in = 32'h6000_0024; cyc(3);
    ale = 0; ad_in = 32'hD4D4_0004; cyc(4);
    rnw = 1; cyc(1);
    bus_read("R2 last address", 32'h6000_0024, 1, 32'hD4D4_0004);
    bus_read("R2 first address untouched", 32'h6000_0020, 1, 32'hE5E5_0005);
  endtask

  task automatic t_single_and_ignore;
    ale = 1; rnw = 0; ad_in = 32'h6000_0030; cyc(3);
    ale = 0; ad_in = 32'hF6F6_0006; cyc(4);
    ad_in = 32'h1111_2222; cyc(6);
    rnw = 1; cyc(1);
    bus_read("R4 single word", 32'h6000_0030, 1, 32'hF6F6_0006);
    rnw = 0; ad_in = 32'h3333_4444; cyc(8);
    rnw = 1; cyc(1);
    bus_read("R3 no strobe ignored", 32'h6000_0030, 1, 32'hF6F6_0006);
  endtask

  task automatic t_miss;
    bus_write(32'h7000_0014, 32'hDEAD_0007);
    bus_write(32'h6000_0214, 32'hDEAD_0008);
    bus_read("R7 write dropped", 32'h6000_0014, 1, 32'hA1A1_0001);
    bus_read("R7 high miss undriven", 32'h7000_0014, 0, 32'h0);
    bus_read("R7 bit9 miss undriven", 32'h6000_0214, 0, 32'h0);
  endtask

  initial begin
    t_reset;
    t_regions;
    t_offset;
    t_last_addr;
    t_single_and_ignore;
    t_miss;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule